// File: doc/BRIEF.md
# Warp Load Coalescer

This block turns one warp-wide load into the smallest set of aligned memory requests. A request carries a byte address for each of 32 lanes, one access size shared by the warp and a predicate mask. The block finds every distinct aligned granule that any enabled lane touches. It then emits one request per granule, one per cycle, over a valid/ready handshake. Each request carries the granule base address and a mask of the lanes it serves.

A granule is a 128-byte line by default. When the sector flag is set it is a 32-byte sector. Lanes are examined in groups of eight. A group whose lanes are all disabled is passed over inside the same cycle's selection, so it never costs a cycle. A request whose mask is all zero produces no output and is retired at once with a done pulse.

Top module: `warp_coalescer`

## Requirements
- R1: In line mode every emitted address is the base of a 128-byte aligned line, so its low 7 bits are zero.
- R2: Lane i takes its address from bits [32*i+31 : 32*i] of `req_addr` and is enabled by bit i of `req_mask`. Bit i of `txn_lanes` stands for the same lane. When 32 lanes read consecutive 4-byte words starting at an aligned line base, exactly one request is emitted. That request carries all 32 lane bits and has `txn_last` set.
- R3: The size code is 0, 1, 2, 3 or 4, giving 1, 2, 4, 8 or 16 bytes. Exactly one request is emitted for each distinct granule touched. Its lane mask holds exactly the enabled lanes that touch that granule.
- R4: With `req_sector` high the granule is 32 bytes, and every emitted address has its low 5 bits zero.
- R5: Disabled lanes never appear in a lane mask and never cause a request. While `txn_ready` is high, requests come on consecutive cycles with no idle cycle between them, whatever groups of eight lanes are disabled.
- R6: Requests are ordered by the lowest-numbered enabled lane touching each granule. Two granules first touched by the same lane are emitted lower address first.
- R7: An access that crosses a granule boundary adds both granules, and the lane appears in both lane masks.
- R8: An accepted request with an all-zero mask emits nothing and raises `done` in the following cycle.
- R9: While `txn_valid` is high and `txn_ready` is low, the address, lane mask and last flag hold steady.
- R10: `req_ready` is low from the accepting edge until the request marked `txn_last` has been handed off. In the cycle after that hand-off, `req_ready` is high again and `done` is high for one cycle.
- R11: After reset, `req_ready` is high and `txn_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Warp request offered |
| req_ready | output | 1 | Block can take a warp request |
| req_addr | input | 1024 | 32 lane byte addresses, lane 0 in the low bits |
| req_size | input | 3 | Access size code, bytes = 2^code |
| req_mask | input | 32 | Lane predicate mask |
| req_sector | input | 1 | Use 32-byte sectors instead of 128-byte lines |
| txn_valid | output | 1 | Memory request offered |
| txn_ready | input | 1 | Downstream takes the memory request |
| txn_addr | output | 32 | Aligned granule base address |
| txn_lanes | output | 32 | Lanes served by this request |
| txn_last | output | 1 | Final request of the warp |
| done | output | 1 | One-cycle pulse after a warp is retired |

## Verification
The checker watches several properties on every cycle. It confirms granule alignment in both modes and that lane masks are non-empty and stay within the captured predicate. It also checks that output stays steady under back-pressure, that no new warp is taken while requests are pending, and that `done` follows the final hand-off or an empty mask. Only the bench scenarios can show the rest: the exact count and order of requests, the lane membership of each one, boundary-crossing accesses, and the absence of idle cycles when whole groups of lanes are disabled. Each of these is compared against a list of expected requests built from the lane addresses.

// File: rtl/coal_pkg.sv
package coal_pkg;

    localparam int LANES         = 32;
    localparam int ADDR_W        = 32;
    localparam int GROUP_SZ      = 8;
    localparam int LINE_LG       = 7;
    localparam int SECTOR_LG     = 5;
    localparam int SIZE_W        = 3;
    localparam int MAX_SIZE_CODE = 4;

    typedef logic [ADDR_W-1:0] addr_t;

    // granule span of one lane: first and last granule index touched
    typedef struct packed {
        addr_t lo;
        addr_t hi;
        logic  split;
    } span_t;

    function automatic addr_t access_bytes(input logic [SIZE_W-1:0] code);
        logic [SIZE_W-1:0] c;
        c = (code > SIZE_W'(MAX_SIZE_CODE)) ? SIZE_W'(MAX_SIZE_CODE) : code;
        return addr_t'(1) << c;
    endfunction

    function automatic logic [$clog2(ADDR_W)-1:0] gran_shift(input logic sector);
        return sector ? ($clog2(ADDR_W))'(SECTOR_LG) : ($clog2(ADDR_W))'(LINE_LG);
    endfunction

endpackage

// File: rtl/coal_lane_span.sv
module coal_lane_span
    import coal_pkg::*;
(
    input  addr_t             addr,
    input  logic [SIZE_W-1:0] size_code,
    input  logic              sector,
    output span_t             span
);
    addr_t                       last_byte;
    logic [$clog2(ADDR_W)-1:0]   sh;

    always_comb begin
        sh         = gran_shift(sector);
        last_byte  = addr + access_bytes(size_code) - addr_t'(1);
        span.lo    = addr >> sh;
        span.hi    = last_byte >> sh;
        span.split = (span.lo != span.hi);
    end
endmodule

// File: rtl/coal_pick.sv
// Two-level first-set search: first non-empty group of lanes, then first lane in it.
module coal_pick #(
    parameter int LANES    = 32,
    parameter int GROUP_SZ = 8,
    localparam int GROUPS  = LANES / GROUP_SZ,
    localparam int IDX_W   = $clog2(LANES)
) (
    input  logic [LANES-1:0] cand,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    logic [GROUPS-1:0] grp_any;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assign grp_any[g] = |cand[g*GROUP_SZ +: GROUP_SZ];
    end

    always_comb begin
        int  grp_sel;
        int  lane_off;
        logic lane_hit;
        grp_sel  = 0;
        found    = 1'b0;
        for (int g = 0; g < GROUPS; g++) begin
            if (!found && grp_any[g]) begin
                found   = 1'b1;
                grp_sel = g;
            end
        end
        lane_off = 0;
        lane_hit = 1'b0;
        for (int j = 0; j < GROUP_SZ; j++) begin
            if (!lane_hit && cand[grp_sel*GROUP_SZ + j]) begin
                lane_hit = 1'b1;
                lane_off = j;
            end
        end
        idx = IDX_W'(grp_sel*GROUP_SZ + lane_off);
    end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
    import coal_pkg::*;
#(
    parameter int LANES    = coal_pkg::LANES,
    parameter int GROUP_SZ = coal_pkg::GROUP_SZ,
    localparam int IDX_W   = $clog2(LANES)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [LANES*ADDR_W-1:0]  req_addr,
    input  logic [SIZE_W-1:0]        req_size,
    input  logic [LANES-1:0]         req_mask,
    input  logic                     req_sector,
    output logic                     txn_valid,
    input  logic                     txn_ready,
    output logic [ADDR_W-1:0]        txn_addr,
    output logic [LANES-1:0]         txn_lanes,
    output logic                     txn_last,
    output logic                     done
);
    logic              busy;
    logic              done_q;
    addr_t             addr_q [LANES];
    logic [SIZE_W-1:0] size_q;
    logic              sector_q;
    logic [LANES-1:0]  pend_lo, pend_hi;

    span_t             spans [LANES];
    logic [LANES-1:0]  split_v, cand, hit_lo, hit_hi;
    logic              pick_found;
    logic [IDX_W-1:0]  pick_idx;
    addr_t             gran_sel;
    logic              accept, fire;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        coal_lane_span u_span (
            .addr      (addr_q[i]),
            .size_code (size_q),
            .sector    (sector_q),
            .span      (spans[i])
        );
        assign split_v[i] = spans[i].split;
        assign hit_lo[i]  = pend_lo[i] && (spans[i].lo == gran_sel);
        assign hit_hi[i]  = pend_hi[i] && split_v[i] && (spans[i].hi == gran_sel);
    end

    assign cand = pend_lo | (pend_hi & split_v);

    coal_pick #(.LANES(LANES), .GROUP_SZ(GROUP_SZ)) u_pick (
        .cand  (cand),
        .found (pick_found),
        .idx   (pick_idx)
    );

    // lower granule of a lane goes first, so a pending lo part wins
    assign gran_sel  = pend_lo[pick_idx] ? spans[pick_idx].lo : spans[pick_idx].hi;

    assign req_ready = !busy;
    assign txn_valid = busy && pick_found;
    assign txn_addr  = gran_sel << gran_shift(sector_q);
    assign txn_lanes = hit_lo | hit_hi;
    assign txn_last  = ((pend_lo & ~hit_lo) | (pend_hi & split_v & ~hit_hi)) == '0;
    assign done      = done_q;

    assign accept = req_valid && req_ready;
    assign fire   = txn_valid && txn_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            done_q   <= 1'b0;
            pend_lo  <= '0;
            pend_hi  <= '0;
            size_q   <= '0;
            sector_q <= 1'b0;
        end else begin
            done_q <= (fire && txn_last) || (accept && (req_mask == '0));
            if (accept) begin
                busy     <= |req_mask;
                pend_lo  <= req_mask;
                pend_hi  <= req_mask;
                size_q   <= req_size;
                sector_q <= req_sector;
            end else if (fire) begin
                pend_lo <= pend_lo & ~hit_lo;
                pend_hi <= pend_hi & ~hit_hi;
                if (txn_last) busy <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            for (int i = 0; i < LANES; i++) addr_q[i] <= req_addr[i*ADDR_W +: ADDR_W];
        end
    end
endmodule

// File: rtl/coal_chk.sv
module coal_chk
    import coal_pkg::*;
#(
    parameter int LANES = coal_pkg::LANES
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     req_valid,
    input logic                     req_ready,
    input logic [LANES-1:0]         req_mask,
    input logic                     req_sector,
    input logic                     txn_valid,
    input logic                     txn_ready,
    input logic [ADDR_W-1:0]        txn_addr,
    input logic [LANES-1:0]         txn_lanes,
    input logic                     txn_last,
    input logic                     done
);
    logic [LANES-1:0] cap_mask;
    logic             cap_sector;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_mask   <= '0;
            cap_sector <= 1'b0;
        end else if (req_valid && req_ready) begin
            cap_mask   <= req_mask;
            cap_sector <= req_sector;
        end
    end

    AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && !cap_sector) |-> (txn_addr[LINE_LG-1:0] == '0)); // R1
    AST_SECTOR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && cap_sector) |-> (txn_addr[SECTOR_LG-1:0] == '0)); // R4
    AST_LANES_ENABLED: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> ((txn_lanes != '0) && ((txn_lanes & ~cap_mask) == '0))); // R5
    AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_addr) && $stable(txn_lanes) && $stable(txn_last))); // R9
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> !req_ready); // R10
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && txn_ready && txn_last) |=> (done && req_ready)); // R10
    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && (req_mask == '0)) |=> (done && !txn_valid)); // R8
endmodule

bind warp_coalescer coal_chk #(.LANES(LANES)) u_coal_chk (
    .clk, .rst, .req_valid, .req_ready, .req_mask, .req_sector,
    .txn_valid, .txn_ready, .txn_addr, .txn_lanes, .txn_last, .done
);

// File: tb/test_warp_coalescer.sv
module test_warp_coalescer;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [NL*32-1:0] req_addr = '0;
    logic [2:0]      req_size = '0;
    logic [NL-1:0]   req_mask = '0;
    logic            req_sector = 1'b0;
    logic            txn_valid;
    logic            txn_ready = 1'b1;
    logic [31:0]     txn_addr;
    logic [NL-1:0]   txn_lanes;
    logic            txn_last;
    logic            done;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] lane_addr [NL];
    logic [31:0] exp_addr  [2*NL];
    logic [NL-1:0] exp_lanes [2*NL];
    int n_exp;

    always #(CLK_PERIOD/2) clk = ~clk;

    warp_coalescer i_warp_coalescer (
        .clk, .rst, .req_valid, .req_ready, .req_addr, .req_size, .req_mask,
        .req_sector, .txn_valid, .txn_ready, .txn_addr, .txn_lanes, .txn_last, .done
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // expected request list from the requirements
    task automatic build_expect(input logic [2:0] sz, input logic [NL-1:0] m, input bit sec);
        int sh;
        logic [31:0] lo, hi, g;
        bit seen;
        sh = sec ? 5 : 7;
        n_exp = 0;
        for (int i = 0; i < NL; i++) begin
            if (m[i]) begin
                lo = lane_addr[i] >> sh;
                hi = (lane_addr[i] + (32'd1 << sz) - 32'd1) >> sh;
                for (int p = 0; p < 2; p++) begin
                    g = (p == 0) ? lo : hi;
                    seen = 1'b0;
                    for (int k = 0; k < n_exp; k++) if (exp_addr[k] == (g << sh)) seen = 1'b1;
                    if (!seen) begin
                        exp_addr[n_exp]  = g << sh;
                        exp_lanes[n_exp] = '0;
                        n_exp++;
                    end
                end
            end
        end
        for (int k = 0; k < n_exp; k++) begin
            for (int i = 0; i < NL; i++) begin
                lo = lane_addr[i] >> sh;
                hi = (lane_addr[i] + (32'd1 << sz) - 32'd1) >> sh;
                if (m[i] && (((lo << sh) == exp_addr[k]) || ((hi << sh) == exp_addr[k])))
                    exp_lanes[k][i] = 1'b1;
            end
        end
    endtask

    task automatic run_case(input string tag, input logic [2:0] sz, input logic [NL-1:0] m,
                            input bit sec, input int stall);
        int k;
        bit got_last;
        logic [31:0] a0;
        logic [NL-1:0] l0;
        build_expect(sz, m, sec);
        @(negedge clk);
        chk(req_ready == 1'b1, {tag, " R10 ready before request"}, 64'(req_ready), 64'd1);
        for (int i = 0; i < NL; i++) req_addr[i*32 +: 32] = lane_addr[i];
        req_size = sz; req_mask = m; req_sector = sec; req_valid = 1'b1;
        txn_ready = (stall == 0);
        @(posedge clk);
        #1 req_valid = 1'b0;
        if (m == '0) begin
            @(negedge clk);
            chk(done == 1'b1 && txn_valid == 1'b0, {tag, " R8 empty mask"}, {62'd0, done, txn_valid}, 64'h2);
            return;
        end
        if (stall > 0) begin
            @(negedge clk);
            a0 = txn_addr; l0 = txn_lanes;
            for (int s = 0; s < stall; s++) begin
                @(negedge clk);
                chk(txn_valid && txn_addr == a0 && txn_lanes == l0, {tag, " R9 held under stall"},
                    64'(txn_addr), 64'(a0));
            end
            txn_ready = 1'b1;
            #1;
        end
        k = 0; got_last = 1'b0;
        for (int c = 0; c < 4*NL && !got_last; c++) begin
            if (!(stall > 0 && c == 0)) @(negedge clk);
            chk(txn_valid == 1'b1, {tag, " R5 no idle cycle"}, 64'(txn_valid), 64'd1);
            chk(req_ready == 1'b0, {tag, " R10 busy blocks requests"}, 64'(req_ready), 64'd0);
            if (k < n_exp) begin
                chk(txn_addr == exp_addr[k], {tag, " address/order"}, 64'(txn_addr), 64'(exp_addr[k]));
                chk(txn_lanes == exp_lanes[k], {tag, " lane mask"}, 64'(txn_lanes), 64'(exp_lanes[k]));
                chk(txn_last == (k == n_exp-1), {tag, " last flag"}, 64'(txn_last), 64'(k == n_exp-1));
            end
            if (txn_last) got_last = 1'b1;
            k++;
        end
        chk(k == n_exp, {tag, " R3 request count"}, 64'(k), 64'(n_exp));
        @(negedge clk);
        chk(done && req_ready && !txn_valid, {tag, " R10 done and ready after last"},
            {61'd0, done, req_ready, txn_valid}, 64'h6);
        @(negedge clk);
        chk(done == 1'b0, {tag, " R10 done is one cycle"}, 64'(done), 64'd0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(req_ready && !txn_valid && !done, "R11 reset state", {61'd0, req_ready, txn_valid, done}, 64'h4);
    endtask

    task automatic t_consecutive_words;
        for (int i = 0; i < NL; i++) lane_addr[i] = 32'h1000 + 32'(4*i);
        run_case("R2 R1 consecutive words", 3'd2, '1, 1'b0, 0);
        chk(n_exp == 1, "R2 single request expected", 64'(n_exp), 64'd1);
    endtask

    task automatic t_wide_access;
        for (int i = 0; i < NL; i++) lane_addr[i] = 32'h2000 + 32'(16*i);
        run_case("R3 16-byte lanes", 3'd4, '1, 1'b0, 0);
    endtask

    task automatic t_sector_mode;
        for (int i = 0; i < NL; i++) lane_addr[i] = 32'h3000 + 32'(4*i);
        run_case("R4 sector mode", 3'd2, '1, 1'b1, 0);
        chk(n_exp == 4, "R4 four sectors expected", 64'(n_exp), 64'd4);
    endtask

    task automatic t_order_and_gaps;
        for (int i = 0; i < NL; i++) lane_addr[i] = 32'h9000 + 32'(128*i);
        lane_addr[4] = 32'h5100; lane_addr[5] = 32'h5000;
        lane_addr[31] = 32'h5104; lane_addr[30] = 32'h4F80;
        run_case("R6 R5 order with idle groups", 3'd2, 32'hC000_0030, 1'b0, 0);
    endtask

    task automatic t_straddle;
        for (int i = 0; i < NL; i++) lane_addr[i] = 32'h0;
        lane_addr[0] = 32'h107C; lane_addr[5] = 32'h1080;
        run_case("R7 boundary crossing", 3'd3, 32'h0000_0021, 1'b0, 0);
        chk(n_exp == 2, "R7 two lines expected", 64'(n_exp), 64'd2);
    endtask

    task automatic t_empty;
        run_case("R8 empty", 3'd2, '0, 1'b0, 0);
    endtask

    task automatic t_stall;
        for (int i = 0; i < NL; i++) lane_addr[i] = 32'h8000 + 32'(64*i);
        run_case("R9 back-pressure", 3'd2, 32'h00FF_00FF, 1'b0, 3);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_consecutive_words();
        t_wide_access();
        t_sector_mode();
        t_order_and_gaps();
        t_straddle();
        t_empty();
        t_stall();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule